// File: doc/BRIEF.md
# Multiply-Align-Add Mantissa Datapath

This block computes the unrounded value of `z + x*y` (or `z - x*y`) on normalized significands. It is the arithmetic core of a fused multiply-add unit. Operand classification beforehand and rounding and packing afterwards are done by neighbouring logic. The caller presents three significands with their explicit leading bit set, two's-complement exponents, signs, a flag that negates the product, a flag saying that `z` is zero, and the round-down mode bit. The caller then waits for the result through a valid/ready handshake.

Inside, the product comes from four half-word partial products. Both terms are then held in one 128-bit frame with the explicit bit at bit 126. The term with the smaller exponent is shifted right, and every bit that falls off is ORed into bit 0. A single magnitude add or subtract follows. A leading-zero count then restores the explicit bit to bit 126. The result leaves as a 56-bit significand: the explicit bit at bit 55, two guard bits below it, and a sticky bit at bit 0. It comes with an exponent, a sign and an exact-zero flag. Every operation takes the same number of cycles.

Top module: `mac_mant_path`

## Requirements
- R1: A new operation is accepted only on a clock edge where `in_valid_i` and `in_ready_o` are both high. `in_ready_o` is high only while the block is idle, and inputs offered while it is busy are ignored and do not change the result.
- R2: `out_valid_o` rises on the 4th rising clock edge after the accepting edge, whatever the operand values.
- R3: Once raised, `out_valid_o` and all result outputs stay constant until an edge with `out_ready_i` high. After that edge `out_valid_o` is low and `in_ready_o` is high.
- R4: The product exponent is `x_exp + y_exp` and the product sign is `x_sign ^ y_sign ^ negate`. When `z_zero_i` is set, the result is the product alone, with that sign.
- R5: A significand product of two or more shifts right by one with sticky and raises the product exponent by one. For example, 1.5 x 1.5 gives significand 1.125 with exponent `x_exp + y_exp + 1`.
- R6: The term with the smaller exponent is shifted right by the exponent difference in the 128-bit frame, and any discarded one bit sets bit 0. A difference of 128 or more leaves only the sticky bit of that term.
- R7: When the product sign equals `z_sign`, the magnitudes are added. A carry into bit 127 gives a one-bit sticky right shift and an exponent increment.
- R8: When the signs differ, the smaller magnitude is subtracted from the larger, and the result takes the sign of the larger term.
- R9: An exact zero difference sets `res_zero_o`, with significand 0, exponent 0 and sign equal to `round_down_i` as captured at acceptance.
- R10: After a subtraction, the result is shifted left until its explicit bit is at bit 126, and the exponent drops by the shift amount.
- R11: A nonzero result has `res_mant_o[55]` set. It is the 128-bit frame shifted right by 71 with sticky, so any one bit below frame bit 71 sets `res_mant_o[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation offered |
| in_ready_o | output | 1 | Block idle, operation can be taken |
| x_mant_i | input | MANT_W | Multiplicand significand, explicit bit at MSB |
| x_exp_i | input | EXP_W | Multiplicand exponent, two's complement |
| x_sign_i | input | 1 | Multiplicand sign |
| y_mant_i | input | MANT_W | Multiplier significand, explicit bit at MSB |
| y_exp_i | input | EXP_W | Multiplier exponent, two's complement |
| y_sign_i | input | 1 | Multiplier sign |
| z_mant_i | input | MANT_W | Addend significand, explicit bit at MSB unless zero |
| z_exp_i | input | EXP_W | Addend exponent, two's complement |
| z_sign_i | input | 1 | Addend sign |
| z_zero_i | input | 1 | Addend is zero, product passes alone |
| negate_i | input | 1 | Negate the product before the add |
| round_down_i | input | 1 | Round-toward-minus-infinity mode, sets the sign of an exact zero |
| out_valid_o | output | 1 | Result available |
| out_ready_i | input | 1 | Result taken |
| res_mant_o | output | MANT_W+3 | Result significand, explicit bit at MSB, sticky at bit 0 |
| res_exp_o | output | EXP_W+2 | Result exponent, two's complement |
| res_sign_o | output | 1 | Result sign |
| res_zero_o | output | 1 | Exact zero result |

## Verification
The bench builds the block with its default parameters: 53-bit significands, 13-bit exponents and 32-bit partial-product halves. This gives the full 128-bit frame, the 71-bit output shift, and exponent gaps from zero to well past the frame width. Directed cases cover the following:
- carry-out on an equal-sign add;
- total cancellation in both rounding modes;
- renormalization after a partial cancellation;
- sticky capture from a distant product;
- a sign taken from the larger addend.

Random vectors keep the exponents near each other so that alignment and cancellation paths occur often. They are compared with a bit-serial wide-integer model of the same frame.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL,
    ST_ALN,
    ST_ADD,
    ST_NRM,
    ST_OUT
  } mac_state_e;

  // edges from acceptance to out_valid
  localparam int unsigned MAC_LAT = 4;

endpackage

// File: rtl/mac_pp_mul.sv
module mac_pp_mul #(
  parameter int unsigned HALF_W = 32
) (
  input  logic [2*HALF_W-1:0] a_i,
  input  logic [2*HALF_W-1:0] b_i,
  output logic [4*HALF_W-1:0] p_o
);

  logic [2*HALF_W-1:0] pp [4];

  for (genvar i = 0; i < 2; i++) begin : g_a
    for (genvar j = 0; j < 2; j++) begin : g_b
      assign pp[i*2+j] = {{HALF_W{1'b0}}, a_i[i*HALF_W +: HALF_W]}
                       * {{HALF_W{1'b0}}, b_i[j*HALF_W +: HALF_W]};
    end
  end

  // weighted sum of partials; carries ripple through the full width
  always_comb begin
    p_o = '0;
    for (int k = 0; k < 4; k++) begin
      p_o = p_o + ({{(2*HALF_W){1'b0}}, pp[k]} << (((k / 2) + (k % 2)) * HALF_W));
    end
  end

endmodule

// File: rtl/mac_sticky_shr.sv
module mac_sticky_shr #(
  parameter int unsigned W     = 128,
  parameter int unsigned AMT_W = 8
) (
  input  logic [W-1:0]     d_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [W-1:0]     q_o
);

  logic [W-1:0] mask;

  always_comb begin
    mask = '1;
    if (amt_i >= AMT_W'(W)) begin
      q_o    = '0;
      q_o[0] = |d_i;
    end else begin
      mask   = ~({W{1'b1}} << amt_i);
      q_o    = d_i >> amt_i;
      q_o[0] = q_o[0] | (|(d_i & mask));
    end
  end

endmodule

// File: rtl/mac_lzc.sv
module mac_lzc #(
  parameter int unsigned W     = 128,
  parameter int unsigned CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     d_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_comb begin
    cnt_o = CNT_W'(W);
    for (int i = 0; i < W; i++) begin
      if (d_i[i]) cnt_o = CNT_W'(W - 1 - i);
    end
  end

endmodule

// File: rtl/mac_mant_path.sv
module mac_mant_path
  import mac_pkg::*;
#(
  parameter int unsigned MANT_W = 53,
  parameter int unsigned EXP_W  = 13,
  parameter int unsigned HALF_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [MANT_W-1:0] x_mant_i,
  input  logic [EXP_W-1:0]  x_exp_i,
  input  logic              x_sign_i,
  input  logic [MANT_W-1:0] y_mant_i,
  input  logic [EXP_W-1:0]  y_exp_i,
  input  logic              y_sign_i,
  input  logic [MANT_W-1:0] z_mant_i,
  input  logic [EXP_W-1:0]  z_exp_i,
  input  logic              z_sign_i,
  input  logic              z_zero_i,
  input  logic              negate_i,
  input  logic              round_down_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [MANT_W+2:0] res_mant_o,
  output logic [EXP_W+1:0]  res_exp_o,
  output logic              res_sign_o,
  output logic              res_zero_o
);

  localparam int unsigned WORD_W = 2 * HALF_W;
  localparam int unsigned WIDE_W = 2 * WORD_W;
  localparam int unsigned OUT_W  = MANT_W + 3;
  localparam int unsigned EXPI_W = EXP_W + 2;
  localparam int unsigned SH_W   = $clog2(WIDE_W) + 1;
  localparam int unsigned CNT_W  = $clog2(WIDE_W + 1);
  localparam int unsigned TOP_SH = WORD_W - MANT_W;
  localparam int unsigned Z_PAD  = WIDE_W - 1 - MANT_W;
  localparam int unsigned EXPL   = WIDE_W - 2;
  localparam int unsigned OUT_SH = EXPL - (OUT_W - 1);

  mac_state_e state_q;

  // operand capture
  logic [MANT_W-1:0] xm_q, ym_q, zm_q;
  logic [EXPI_W-1:0] xe_q, ye_q, ze_q;
  logic              zs_q, rs_q, zz_q, rd_q;

  // stage registers
  logic [WIDE_W-1:0] prod_q, pa_q, za_q, acc_q;
  logic [EXPI_W-1:0] pe_q, ce_q, ae_q;
  logic              sgn_q, sub_q, zero_q;

  // result registers
  logic              out_valid_q;
  logic [OUT_W-1:0]  res_mant_q;
  logic [EXPI_W-1:0] res_exp_q;
  logic              res_sign_q, res_zero_q;

  assign in_ready_o  = (state_q == ST_IDLE);
  assign out_valid_o = out_valid_q;
  assign res_mant_o  = res_mant_q;
  assign res_exp_o   = res_exp_q;
  assign res_sign_o  = res_sign_q;
  assign res_zero_o  = res_zero_q;

  logic accept;
  assign accept = in_valid_i && in_ready_o;

  // ---------------- multiply ----------------
  logic [WORD_W-1:0] xa, ya;
  logic [WIDE_W-1:0] prod_raw, prod_n;
  logic [EXPI_W-1:0] pe_n;

  assign xa = {xm_q, {TOP_SH{1'b0}}};
  assign ya = {ym_q, {TOP_SH{1'b0}}};

  mac_pp_mul #(.HALF_W(HALF_W)) u_mul (
    .a_i(xa),
    .b_i(ya),
    .p_o(prod_raw)
  );

  always_comb begin
    prod_n = prod_raw;
    pe_n   = xe_q + ye_q;
    if (prod_raw[WIDE_W-1]) begin
      prod_n = {1'b0, prod_raw[WIDE_W-1:2], prod_raw[1] | prod_raw[0]};
      pe_n   = xe_q + ye_q + EXPI_W'(1);
    end
  end

  // ---------------- align ----------------
  logic [WIDE_W-1:0] z_place, aln_in, aln_out, pa_n, za_n;
  logic [EXPI_W-1:0] e_gap, ce_n;
  logic [SH_W-1:0]   aln_amt;
  logic              z_big;

  assign z_place = {1'b0, zm_q, {Z_PAD{1'b0}}};
  assign z_big   = $signed(ze_q) > $signed(pe_q);
  assign e_gap   = z_big ? (ze_q - pe_q) : (pe_q - ze_q);
  assign aln_amt = (e_gap >= EXPI_W'(WIDE_W)) ? SH_W'(WIDE_W) : e_gap[SH_W-1:0];
  assign aln_in  = z_big ? prod_q : z_place;

  mac_sticky_shr #(.W(WIDE_W), .AMT_W(SH_W)) u_aln (
    .d_i  (aln_in),
    .amt_i(aln_amt),
    .q_o  (aln_out)
  );

  always_comb begin
    if (zz_q) begin
      pa_n = prod_q;
      za_n = '0;
      ce_n = pe_q;
    end else if (z_big) begin
      pa_n = aln_out;
      za_n = z_place;
      ce_n = ze_q;
    end else begin
      pa_n = prod_q;
      za_n = aln_out;
      ce_n = pe_q;
    end
  end

  // ---------------- add / subtract ----------------
  logic              eff_sub, z_ge;
  logic [WIDE_W-1:0] sum_n;
  logic              sgn_n;

  assign eff_sub = !zz_q && (zs_q != rs_q);
  assign z_ge    = za_q >= pa_q;

  always_comb begin
    if (!eff_sub) begin
      sum_n = pa_q + za_q;
      sgn_n = rs_q;
    end else if (z_ge) begin
      sum_n = za_q - pa_q;
      sgn_n = zs_q;
    end else begin
      sum_n = pa_q - za_q;
      sgn_n = rs_q;
    end
  end

  // ---------------- normalize ----------------
  logic [WIDE_W-1:0] car_w, norm_w, fin_w;
  logic [EXPI_W-1:0] norm_e;
  logic [CNT_W-1:0]  lz;

  mac_sticky_shr #(.W(WIDE_W), .AMT_W(SH_W)) u_car (
    .d_i  (acc_q),
    .amt_i(SH_W'(1)),
    .q_o  (car_w)
  );

  mac_lzc #(.W(WIDE_W), .CNT_W(CNT_W)) u_lzc (
    .d_i  (acc_q),
    .cnt_o(lz)
  );

  always_comb begin
    norm_w = acc_q;
    norm_e = ae_q;
    if (!sub_q) begin
      if (acc_q[WIDE_W-1]) begin
        norm_w = car_w;
        norm_e = ae_q + EXPI_W'(1);
      end
    end else begin
      norm_w = acc_q << (lz - CNT_W'(1));
      norm_e = ae_q - EXPI_W'(lz) + EXPI_W'(1);
    end
  end

  mac_sticky_shr #(.W(WIDE_W), .AMT_W(SH_W)) u_fin (
    .d_i  (norm_w),
    .amt_i(SH_W'(OUT_SH)),
    .q_o  (fin_w)
  );

  // ---------------- sequencing ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      xm_q        <= '0;
      ym_q        <= '0;
      zm_q        <= '0;
      xe_q        <= '0;
      ye_q        <= '0;
      ze_q        <= '0;
      zs_q        <= 1'b0;
      rs_q        <= 1'b0;
      zz_q        <= 1'b0;
      rd_q        <= 1'b0;
      prod_q      <= '0;
      pe_q        <= '0;
      pa_q        <= '0;
      za_q        <= '0;
      ce_q        <= '0;
      acc_q       <= '0;
      ae_q        <= '0;
      sgn_q       <= 1'b0;
      sub_q       <= 1'b0;
      zero_q      <= 1'b0;
      out_valid_q <= 1'b0;
      res_mant_q  <= '0;
      res_exp_q   <= '0;
      res_sign_q  <= 1'b0;
      res_zero_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            xm_q    <= x_mant_i;
            ym_q    <= y_mant_i;
            zm_q    <= z_mant_i;
            xe_q    <= {{2{x_exp_i[EXP_W-1]}}, x_exp_i};
            ye_q    <= {{2{y_exp_i[EXP_W-1]}}, y_exp_i};
            ze_q    <= {{2{z_exp_i[EXP_W-1]}}, z_exp_i};
            zs_q    <= z_sign_i;
            rs_q    <= x_sign_i ^ y_sign_i ^ negate_i;
            zz_q    <= z_zero_i;
            rd_q    <= round_down_i;
            state_q <= ST_MUL;
          end
        end
        ST_MUL: begin
          prod_q  <= prod_n;
          pe_q    <= pe_n;
          state_q <= ST_ALN;
        end
        ST_ALN: begin
          pa_q    <= pa_n;
          za_q    <= za_n;
          ce_q    <= ce_n;
          state_q <= ST_ADD;
        end
        ST_ADD: begin
          acc_q   <= sum_n;
          ae_q    <= ce_q;
          sgn_q   <= sgn_n;
          sub_q   <= eff_sub;
          zero_q  <= eff_sub && (sum_n == '0);
          state_q <= ST_NRM;
        end
        ST_NRM: begin
          out_valid_q <= 1'b1;
          if (zero_q) begin
            res_mant_q <= '0;
            res_exp_q  <= '0;
            res_sign_q <= rd_q;
            res_zero_q <= 1'b1;
          end else begin
            res_mant_q <= fin_w[OUT_W-1:0];
            res_exp_q  <= norm_e;
            res_sign_q <= sgn_q;
            res_zero_q <= 1'b0;
          end
          state_q <= ST_OUT;
        end
        ST_OUT: begin
          if (out_ready_i) begin
            out_valid_q <= 1'b0;
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  logic [3:0] lat_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                lat_cnt_q <= '0;
    else if (accept)            lat_cnt_q <= '0;
    else if (lat_cnt_q != 4'hf) lat_cnt_q <= lat_cnt_q + 4'd1;
  end

  // R1
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !in_ready_o);

  // R1
  normalized_inputs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> x_mant_i[MANT_W-1] && y_mant_i[MANT_W-1] && (z_zero_i || z_mant_i[MANT_W-1]));

  // R2
  fixed_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> lat_cnt_q == 4'(MAC_LAT));

  // R3
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(res_mant_o) && $stable(res_exp_o)
                                    && $stable(res_sign_o) && $stable(res_zero_o));

  // R5
  product_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ALN |-> prod_q[EXPL] && !prod_q[WIDE_W-1]);

  // R8
  diff_no_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_NRM && sub_q |-> !acc_q[WIDE_W-1]);

  // R9
  zero_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && res_zero_o |-> res_mant_o == '0);

  // R11
  explicit_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !res_zero_o |-> res_mant_o[OUT_W-1]);

  // R11
  fin_upper_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_NRM && !zero_q |-> fin_w[WIDE_W-1:OUT_W] == '0);

endmodule

// File: tb/mac_mant_path_tb_top.sv
`timescale 1ns/1ps
module mac_mant_path_tb_top;

  localparam int unsigned MANT_W = 53;
  localparam int unsigned EXP_W  = 13;
  localparam int unsigned HALF_W = 32;
  localparam int unsigned OUT_W  = MANT_W + 3;
  localparam int unsigned EO_W   = EXP_W + 2;
  localparam logic [MANT_W-1:0] ONE  = {1'b1, {(MANT_W-1){1'b0}}};
  localparam logic [MANT_W-1:0] ONEH = {2'b11, {(MANT_W-2){1'b0}}};
  localparam logic [OUT_W-1:0]  R_ONE = {1'b1, {(OUT_W-1){1'b0}}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              in_valid = 1'b0, in_ready;
  logic [MANT_W-1:0] x_mant = '0, y_mant = '0, z_mant = '0;
  logic [EXP_W-1:0]  x_exp = '0, y_exp = '0, z_exp = '0;
  logic              x_sign = 1'b0, y_sign = 1'b0, z_sign = 1'b0;
  logic              z_zero = 1'b0, negate = 1'b0, round_down = 1'b0;
  logic              out_valid, out_ready = 1'b0;
  logic [OUT_W-1:0]  res_mant;
  logic [EO_W-1:0]   res_exp;
  logic              res_sign, res_zero;

  mac_mant_path #(.MANT_W(MANT_W), .EXP_W(EXP_W), .HALF_W(HALF_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .x_mant_i(x_mant), .x_exp_i(x_exp), .x_sign_i(x_sign),
    .y_mant_i(y_mant), .y_exp_i(y_exp), .y_sign_i(y_sign),
    .z_mant_i(z_mant), .z_exp_i(z_exp), .z_sign_i(z_sign),
    .z_zero_i(z_zero), .negate_i(negate), .round_down_i(round_down),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .res_mant_o(res_mant), .res_exp_o(res_exp),
    .res_sign_o(res_sign), .res_zero_o(res_zero)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [MANT_W-1:0] op_xm, op_ym, op_zm;
  logic [EXP_W-1:0]  op_xe, op_ye, op_ze;
  logic              op_xs, op_ys, op_zs, op_zz, op_neg, op_rd;

  logic [OUT_W-1:0]  got_m;
  logic [EO_W-1:0]   got_e;
  logic              got_s, got_z;
  int                got_lat;

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_op(input logic [MANT_W-1:0] xm, input int xe, input bit xs,
                        input logic [MANT_W-1:0] ym, input int ye, input bit ys,
                        input logic [MANT_W-1:0] zm, input int ze, input bit zs,
                        input bit zz, input bit neg, input bit rd);
    op_xm = xm; op_xe = xe[EXP_W-1:0]; op_xs = xs;
    op_ym = ym; op_ye = ye[EXP_W-1:0]; op_ys = ys;
    op_zm = zm; op_ze = ze[EXP_W-1:0]; op_zs = zs;
    op_zz = zz; op_neg = neg; op_rd = rd;
  endtask

  function automatic logic [127:0] sr(input logic [127:0] v, input int n);
    logic [127:0] t = v;
    for (int k = 0; k < n && k < 200; k++) t = (t >> 1) | {127'b0, t[0]};
    return t;
  endfunction

  // bit-serial wide-integer model of the requirements
  task automatic ref_model(output logic [OUT_W-1:0] m, output logic [EO_W-1:0] e,
                           output logic s, output logic zr);
    logic [127:0] xa, ya, p, za, acc;
    int pe, ze, ce;
    logic ps;
    xa = {75'b0, op_xm} << 11;
    ya = {75'b0, op_ym} << 11;
    p  = xa * ya;
    pe = int'($signed(op_xe)) + int'($signed(op_ye));
    if (p[127]) begin p = sr(p, 1); pe++; end
    ps = op_xs ^ op_ys ^ op_neg;
    zr = 1'b0;
    if (op_zz) begin
      acc = p; ce = pe; s = ps;
    end else begin
      za = {1'b0, op_zm, 74'b0};
      ze = int'($signed(op_ze));
      if (ze > pe) begin p = sr(p, ze - pe); ce = ze; end
      else begin za = sr(za, pe - ze); ce = pe; end
      if (op_zs == ps) begin
        acc = p + za; s = ps;
        if (acc[127]) begin acc = sr(acc, 1); ce++; end
      end else begin
        if (za >= p) begin acc = za - p; s = op_zs; end
        else begin acc = p - za; s = ps; end
        if (acc == 0) zr = 1'b1;
        else begin
          for (int k = 0; k < 128 && !acc[126]; k++) begin acc = acc << 1; ce--; end
        end
      end
    end
    if (zr) begin
      m = '0; e = '0; s = op_rd;
    end else begin
      acc = sr(acc, 71);
      m = acc[OUT_W-1:0];
      e = ce[EO_W-1:0];
    end
  endtask

  task automatic run_op(input int hold, input bit poke);
    @(negedge clk);
    in_valid = 1'b1;
    x_mant = op_xm; x_exp = op_xe; x_sign = op_xs;
    y_mant = op_ym; y_exp = op_ye; y_sign = op_ys;
    z_mant = op_zm; z_exp = op_ze; z_sign = op_zs;
    z_zero = op_zz; negate = op_neg; round_down = op_rd;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (poke) begin
      in_valid = 1'b1;
      x_mant = ~op_xm; x_exp = op_xe + 13'd5; z_zero = ~op_zz;
      negate = ~op_neg; round_down = ~op_rd; z_sign = ~op_zs;
    end
    got_lat = 0;
    while (!out_valid && got_lat < 40) begin
      @(negedge clk);
      got_lat++;
      if (poke && !out_valid) chk("R1", "in_ready while busy", 64'(in_ready), 64'd0);
    end
    in_valid = 1'b0;
    got_m = res_mant; got_e = res_exp; got_s = res_sign; got_z = res_zero;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R3", "valid held", 64'(out_valid), 64'd1);
      chk("R3", "mant held", 64'(res_mant), 64'(got_m));
      chk("R3", "exp held", 64'(res_exp), 64'(got_e));
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R3", "valid after pop", 64'(out_valid), 64'd0);
    chk("R3", "ready after pop", 64'(in_ready), 64'd1);
  endtask

  task automatic check_exp(input string req, input logic [OUT_W-1:0] m, input int e,
                           input bit s, input bit z);
    logic [EO_W-1:0] ee = e[EO_W-1:0];
    chk(req, "mant", 64'(got_m), 64'(m));
    chk(req, "exp", 64'(got_e), 64'(ee));
    chk(req, "sign", 64'(got_s), 64'(s));
    chk(req, "zero", 64'(got_z), 64'(z));
    chk("R2", "latency", 64'(got_lat), 64'd4);
  endtask

  task automatic check_ref(input string req);
    logic [OUT_W-1:0] m;
    logic [EO_W-1:0]  e;
    logic             s, z;
    ref_model(m, e, s, z);
    chk(req, "mant vs model", 64'(got_m), 64'(m));
    chk(req, "exp vs model", 64'(got_e), 64'(e));
    chk(req, "sign vs model", 64'(got_s), 64'(s));
    chk(req, "zero vs model", 64'(got_z), 64'(z));
    chk("R2", "latency", 64'(got_lat), 64'd4);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk("R3", "valid in reset", 64'(out_valid), 64'd0);
    chk("R9", "zero flag in reset", 64'(res_zero), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", 64'(in_ready), 64'd1);
  endtask

  task automatic t_product_only();
    // R4: 1.0 * 1.0, addend zero
    set_op(ONE, 0, 0, ONE, 0, 0, ONE, 0, 0, 1, 0, 0);
    run_op(0, 0);
    check_exp("R4", R_ONE, 0, 0, 0);
    // R4: negated product and sign product
    set_op(ONE, 7, 1, ONE, -3, 0, ONE, 0, 0, 1, 1, 0);
    run_op(0, 0);
    check_exp("R4", R_ONE, 4, 0, 0);
    // R5: 1.5 * 1.5 = 1.125 * 2^1
    set_op(ONEH, 3, 1, ONEH, -5, 0, ONE, 0, 0, 1, 0, 0);
    run_op(0, 0);
    check_exp("R5", {4'b1001, {(OUT_W-4){1'b0}}}, -1, 1, 0);
  endtask

  task automatic t_carry();
    // R7: 1*1 + 1 carries out
    set_op(ONE, 0, 0, ONE, 0, 0, ONE, 0, 0, 0, 0, 0);
    run_op(0, 0);
    check_exp("R7", R_ONE, 1, 0, 0);
  endtask

  task automatic t_cancel();
    // R9: 1 - 1*1 in both modes
    set_op(ONE, 0, 0, ONE, 0, 0, ONE, 0, 0, 0, 1, 0);
    run_op(0, 0);
    check_exp("R9", '0, 0, 0, 1);
    set_op(ONE, 0, 0, ONE, 0, 0, ONE, 0, 0, 0, 1, 1);
    run_op(0, 0);
    check_exp("R9", '0, 0, 1, 1);
  endtask

  task automatic t_renorm();
    // R10: 1.5 - 1.0 = 0.5
    set_op(ONEH, 0, 0, ONE, 0, 0, ONE, 0, 1, 0, 0, 0);
    run_op(0, 0);
    check_exp("R10", R_ONE, -1, 0, 0);
  endtask

  task automatic t_sticky();
    // R6 / R11: distant product lands in sticky
    set_op(ONE, -100, 0, ONE, 0, 0, ONE, 0, 0, 0, 0, 0);
    run_op(0, 0);
    check_exp("R11", R_ONE | OUT_W'(1), 0, 0, 0);
    // R6: gap beyond the frame
    set_op(ONE, -300, 0, ONE, 0, 0, ONE, 0, 0, 0, 0, 0);
    run_op(0, 0);
    check_exp("R6", R_ONE | OUT_W'(1), 0, 0, 0);
  endtask

  task automatic t_larger_sign();
    // R8: -2 + 1 = -1
    set_op(ONE, 0, 0, ONE, 0, 0, ONE, 1, 1, 0, 0, 0);
    run_op(0, 0);
    check_exp("R8", R_ONE, 0, 1, 0);
  endtask

  task automatic t_handshake();
    // R1 / R3: inputs offered while busy, result held
    set_op(ONEH, 2, 0, ONEH, 1, 1, ONE, 4, 0, 0, 0, 0);
    run_op(3, 1);
    check_ref("R1");
  endtask

  task automatic t_random();
    for (int k = 0; k < 300; k++) begin
      logic [63:0] r1, r2, r3;
      logic [MANT_W-1:0] xm, ym, zm;
      int xe, ye, ze, mode;
      r1 = {$urandom, $urandom};
      r2 = {$urandom, $urandom};
      r3 = {$urandom, $urandom};
      xm = {1'b1, r1[MANT_W-2:0]};
      ym = {1'b1, r2[MANT_W-2:0]};
      zm = {1'b1, r3[MANT_W-2:0]};
      xe = int'($urandom_range(0, 60)) - 30;
      ye = int'($urandom_range(0, 60)) - 30;
      mode = int'($urandom_range(0, 7));
      if (mode < 4) ze = xe + ye + int'($urandom_range(0, 2)) - 1;
      else          ze = xe + ye + int'($urandom_range(0, 300)) - 150;
      if (mode == 0) begin ym = ONE; zm = xm; ze = xe + ye; end
      set_op(xm, xe, r1[63], ym, ye, r2[63], zm, ze, r3[63], mode == 7, r1[62], r2[62]);
      run_op((k % 9 == 0) ? 1 : 0, k % 11 == 0);
      check_ref("R8");
    end
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL R2 watchdog expired: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_product_only();
    t_carry();
    t_cancel();
    t_renorm();
    t_sticky();
    t_larger_sign();
    t_handshake();
    t_random();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule